// File: doc/BRIEF.md
# Nibble-Command Serial Configuration Slave

This block is a serial slave that configures a bank of sixteen 16-bit ports through short fixed-length commands. While the active-low select is held low, each group of eight serial bits forms one command. The first four bits carry an internal target code and the last four carry a data nibble. Both fields arrive least significant bit first.

A 16-bit holding word and a port pointer are filled one nibble at a time. A separate execute command then commits the whole holding word to the port that the pointer selects. The commit appears as a single-cycle write strobe with a port index and data, in the system clock domain.

A mode register chooses between a separate-line (4-wire) data path and a shared-line (3-wire) data path. Reads are not part of this block, so the serial output driver is never enabled. The serial pins are oversampled by the system clock through synchronisers. Data is captured on each synchronised rising SCLK edge.

Top module: `nib_cfg_slave`

## Requirements
- R1: A command is eight DI bits sampled on rising SCLK while cs_ni is low. Bits 1 to 4 form the target code, LSB first. Bits 5 to 8 form the data nibble, LSB first. Consecutive commands may follow inside one select frame.
- R2: Target codes 0, 1, 2 and 3 load the data nibble into holding word bits [3:0], [7:4], [11:8] and [15:12] respectively.
- R3: Target code 4 loads the data nibble into the port pointer. Codes 5, 6 and 7 address the upper pointer nibbles and leave the port index unchanged.
- R4: Target code 8 raises port_we_o for exactly one clock, with port_idx_o equal to the pointer and port_data_o equal to the holding word. port_we_o rises after the third clock edge following the first clock edge that samples the eighth SCLK high. port_idx_o and port_data_o hold their values between strobes.
- R5: Target code 15 is the mode register. Data 0 selects 4-wire mode (wire3_o = 0) and data 1 selects 3-wire mode (wire3_o = 1). Data 2 to 15 leave the mode unchanged.
- R6: After reset, wire3_o is 1, port_we_o is 0, and port_idx_o and port_data_o are 0.
- R7: Raising cs_ni discards a partial command. SCLK edges seen while cs_ni is high are ignored. The next frame starts at bit 1.
- R8: Target codes 9 to 14 change neither the holding word, the pointer, the mode, nor the outputs.
- R9: do_oe_o stays 0 at all times, so the DO driver is tri-stated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock |
| cs_ni | input | 1 | Serial select, active low |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Serial data out driver enable |
| port_we_o | output | 1 | One-cycle port write strobe |
| port_idx_o | output | 4 | Index of the port written |
| port_data_o | output | 16 | Data written to the port |
| wire3_o | output | 1 | 1 = 3-wire mode, 0 = 4-wire mode |

## Verification
The assertions take for granted that each SCLK phase lasts several system clocks. They also assume that DI and the select are settled before the synchroniser samples the rising SCLK. Under those conditions all three inputs reach the edge detector together.

The stimulus holds each SCLK phase for four system clocks. It changes DI and the select only while SCLK is low, at the falling system clock edge. The partial-frame case raises the select mid-command and then toggles SCLK while deselected, to show that the bit count restarts cleanly.

// File: rtl/nib_cfg_pkg.sv
package nib_cfg_pkg;
  localparam int unsigned NIB_W = 4;
  localparam int unsigned CMD_W = 2 * NIB_W;

  typedef enum logic [NIB_W-1:0] {
    OP_HOLD0 = 4'd0,
    OP_HOLD1 = 4'd1,
    OP_HOLD2 = 4'd2,
    OP_HOLD3 = 4'd3,
    OP_PTR0  = 4'd4,
    OP_PTR1  = 4'd5,
    OP_PTR2  = 4'd6,
    OP_PTR3  = 4'd7,
    OP_EXEC  = 4'd8,
    OP_MODE  = 4'd15
  } op_e;

  localparam logic [NIB_W-1:0] MODE_4W = 4'd0;
  localparam logic [NIB_W-1:0] MODE_3W = 4'd1;
endpackage

// File: rtl/nib_cfg_sync.sv
module nib_cfg_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg[g] <= RST_VAL;
      else if (g == 0) stg[g] <= d_i;
      else             stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/nib_cfg_shift.sv
module nib_cfg_shift
  import nib_cfg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sclk_s_i,
  input  logic             cs_ns_i,
  input  logic             di_s_i,
  output logic             cmd_valid_o,
  output logic [NIB_W-1:0] cmd_op_o,
  output logic [NIB_W-1:0] cmd_nib_o
);
  localparam int unsigned CNT_W = $clog2(CMD_W);

  logic             sclk_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CMD_W-1:0] sh_q;
  logic             rise;

  assign rise = sclk_s_i & ~sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q      <= 1'b0;
      cnt_q       <= '0;
      sh_q        <= '0;
      cmd_valid_o <= 1'b0;
    end else begin
      sclk_q      <= sclk_s_i;
      cmd_valid_o <= 1'b0;
      if (cs_ns_i) begin
        cnt_q <= '0;  // deselect drops any partial command
      end else if (rise) begin
        sh_q <= {di_s_i, sh_q[CMD_W-1:1]};  // LSB arrives first
        if (cnt_q == CNT_W'(CMD_W-1)) begin
          cnt_q       <= '0;
          cmd_valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cmd_op_o  = sh_q[NIB_W-1:0];
  assign cmd_nib_o = sh_q[CMD_W-1:NIB_W];
endmodule

// File: rtl/nib_cfg_regs.sv
module nib_cfg_regs
  import nib_cfg_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [NIB_W-1:0]  cmd_op_i,
  input  logic [NIB_W-1:0]  cmd_nib_i,
  output logic              port_we_o,
  output logic [IDX_W-1:0]  port_idx_o,
  output logic [WORD_W-1:0] port_data_o,
  output logic              wire3_o
);
  localparam int unsigned NIBS = WORD_W / NIB_W;

  logic [WORD_W-1:0] hold_q;
  logic [IDX_W-1:0]  ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q      <= '0;
      ptr_q       <= '0;
      port_we_o   <= 1'b0;
      port_idx_o  <= '0;
      port_data_o <= '0;
      wire3_o     <= 1'b1;
    end else begin
      port_we_o <= 1'b0;
      if (cmd_valid_i) begin
        for (int i = 0; i < NIBS; i++) begin
          if (cmd_op_i == NIB_W'(i)) hold_q[i*NIB_W +: NIB_W] <= cmd_nib_i;
        end
        case (cmd_op_i)
          OP_PTR0: ptr_q <= cmd_nib_i[IDX_W-1:0];
          OP_PTR1, OP_PTR2, OP_PTR3: ;  // upper pointer nibbles do not reach the index
          OP_EXEC: begin
            port_we_o   <= 1'b1;
            port_idx_o  <= ptr_q;
            port_data_o <= hold_q;
          end
          OP_MODE: begin
            if (cmd_nib_i == MODE_4W)      wire3_o <= 1'b0;
            else if (cmd_nib_i == MODE_3W) wire3_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nib_cfg_slave.sv
module nib_cfg_slave
  import nib_cfg_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned IDX_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              di_i,
  output logic              do_o,
  output logic              do_oe_o,
  output logic              port_we_o,
  output logic [IDX_W-1:0]  port_idx_o,
  output logic [WORD_W-1:0] port_data_o,
  output logic              wire3_o
);
  logic [2:0]       pins_s;
  logic             sclk_s, cs_s, di_s;
  logic             cmd_valid;
  logic [NIB_W-1:0] cmd_op, cmd_nib;

  nib_cfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({di_i, cs_ni, sclk_i}),
    .q_o   (pins_s)
  );
  assign sclk_s = pins_s[0];
  assign cs_s   = pins_s[1];
  assign di_s   = pins_s[2];

  nib_cfg_shift i_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_s_i   (sclk_s),
    .cs_ns_i    (cs_s),
    .di_s_i     (di_s),
    .cmd_valid_o(cmd_valid),
    .cmd_op_o   (cmd_op),
    .cmd_nib_o  (cmd_nib)
  );

  nib_cfg_regs #(.WORD_W(WORD_W), .IDX_W(IDX_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid),
    .cmd_op_i   (cmd_op),
    .cmd_nib_i  (cmd_nib),
    .port_we_o  (port_we_o),
    .port_idx_o (port_idx_o),
    .port_data_o(port_data_o),
    .wire3_o    (wire3_o)
  );

  // no read path: output driver stays off in both modes
  assign do_o    = 1'b0;
  assign do_oe_o = 1'b0;
endmodule

// File: rtl/nib_cfg_chk.sv
module nib_cfg_chk #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic              cs_s_i,
  input logic              port_we_i,
  input logic [IDX_W-1:0]  port_idx_i,
  input logic [WORD_W-1:0] port_data_i,
  input logic              wire3_i
);
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_we_i |=> !port_we_i);  // R4
  AST_STROBE_FROM_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_we_i |-> $past(cmd_valid_i));  // R4
  AST_DATA_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_we_i |-> $stable(port_data_i));  // R4
  AST_IDX_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_we_i |-> $stable(port_idx_i));  // R4
  AST_MODE_FROM_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(wire3_i) |-> $past(cmd_valid_i));  // R5
  AST_CMD_NEEDS_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> $past(!cs_s_i));  // R7
endmodule

bind nib_cfg_slave nib_cfg_chk #(.WORD_W(WORD_W), .IDX_W(IDX_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_valid_i(cmd_valid),
  .cs_s_i     (cs_s),
  .port_we_i  (port_we_o),
  .port_idx_i (port_idx_o),
  .port_data_i(port_data_o),
  .wire3_i    (wire3_o)
);

// File: tb/test_nib_cfg_slave.sv
module test_nib_cfg_slave;
  localparam int CLK_P  = 10;
  localparam int HALF   = 4;
  localparam int WD_LIM = 50000;

  logic clk_i = 1'b0, rst_ni = 1'b0, sclk_i = 1'b0, cs_ni = 1'b1, di_i = 1'b0;
  logic do_o, do_oe_o, port_we_o, wire3_o;
  logic [3:0]  port_idx_o;
  logic [15:0] port_data_o;

  int checks = 0, errors = 0, cyc = 0;

  nib_cfg_slave i_nib_cfg_slave (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .cs_ni(cs_ni), .di_i(di_i),
    .do_o(do_o), .do_oe_o(do_oe_o), .port_we_o(port_we_o),
    .port_idx_o(port_idx_o), .port_data_o(port_data_o), .wire3_o(wire3_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: pin samples -> command list -> output snapshots 3 edges later
  typedef struct packed {logic we; logic [3:0] idx; logic [15:0] data; logic mode;} snap_t;
  snap_t pipe[$];
  snap_t cur;
  logic m_prev;
  int   m_cnt;
  logic [7:0]  m_bits;
  logic [15:0] m_hold;
  logic [3:0]  m_ptr;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_prev = 1'b0; m_cnt = 0; m_bits = '0; m_hold = '0; m_ptr = '0;
      cur = '{we: 1'b0, idx: 4'h0, data: 16'h0, mode: 1'b1};
      pipe = {cur, cur, cur, cur};
    end else begin
      logic rise;
      cur.we = 1'b0;
      rise = sclk_i && !m_prev;
      m_prev = sclk_i;
      if (cs_ni) m_cnt = 0;
      else if (rise) begin
        m_bits[m_cnt] = di_i;
        m_cnt++;
        if (m_cnt == 8) begin
          int op;
          logic [3:0] nib;
          m_cnt = 0;
          op  = int'(m_bits[3:0]);
          nib = m_bits[7:4];
          if (op < 4) m_hold[op*4 +: 4] = nib;
          else if (op == 4) m_ptr = nib;
          else if (op == 8) begin cur.we = 1'b1; cur.idx = m_ptr; cur.data = m_hold; end
          else if (op == 15) begin
            if (nib == 4'd0) cur.mode = 1'b0;
            else if (nib == 4'd1) cur.mode = 1'b1;
          end
        end
      end
      pipe.push_back(cur);
      if (pipe.size() > 4) void'(pipe.pop_front());
    end
  end

  // per-clock comparison against the model
  int seen = 0;
  logic [3:0]  last_idx = '0;
  logic [15:0] last_data = '0;
  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R4 strobe",  32'(port_we_o),   32'(pipe[0].we));
      chk("R4 index",   32'(port_idx_o),  32'(pipe[0].idx));
      chk("R4 data",    32'(port_data_o), 32'(pipe[0].data));
      chk("R5 mode",    32'(wire3_o),     32'(pipe[0].mode));
      chk("R9 do_oe",   32'(do_oe_o),     32'd0);
      if (port_we_o) begin seen++; last_idx = port_idx_o; last_data = port_data_o; end
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == WD_LIM) begin
      errors++;
      $display("FAIL watchdog R1 actual %0d expected < %0d", cyc, WD_LIM);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_bit(input logic b);
    sclk_i = 1'b0; di_i = b;
    wait_clk(HALF);
    sclk_i = 1'b1;
    wait_clk(HALF);
  endtask

  task automatic send_cmd(input logic [3:0] op, input logic [3:0] nib);
    for (int i = 0; i < 4; i++) send_bit(op[i]);
    for (int i = 0; i < 4; i++) send_bit(nib[i]);
  endtask

  task automatic sel;   sclk_i = 1'b0; cs_ni = 1'b0; wait_clk(HALF); endtask
  task automatic desel; sclk_i = 1'b0; wait_clk(HALF); cs_ni = 1'b1; wait_clk(10); endtask

  initial begin
    wait_clk(3);
    chk("R6 mode in reset", 32'(wire3_o), 32'd1);
    rst_ni = 1'b1;
    wait_clk(2);
    chk("R6 mode", 32'(wire3_o), 32'd1);
    chk("R6 strobe", 32'(port_we_o), 32'd0);
    chk("R6 data", 32'(port_data_o), 32'd0);
    chk("R9 driver off", 32'(do_oe_o), 32'd0);

    // R1 R2 R3 R4: nibble assembly, several commands in one frame
    sel;
    send_cmd(4'd0, 4'h3); send_cmd(4'd1, 4'hC); send_cmd(4'd2, 4'h5); send_cmd(4'd3, 4'hA);
    send_cmd(4'd4, 4'h7); send_cmd(4'd5, 4'hF); send_cmd(4'd6, 4'h2); send_cmd(4'd7, 4'h9);
    send_cmd(4'd8, 4'h0);
    desel;
    chk("R4 count", 32'(seen), 32'd1);
    chk("R3 index", 32'(last_idx), 32'h7);
    chk("R2 data", 32'(last_data), 32'hA5C3);

    // R8: unused codes change nothing
    sel;
    for (int c = 9; c < 15; c++) send_cmd(4'(c), 4'hF);
    send_cmd(4'd8, 4'h0);
    desel;
    chk("R8 count", 32'(seen), 32'd2);
    chk("R8 index", 32'(last_idx), 32'h7);
    chk("R8 data", 32'(last_data), 32'hA5C3);
    chk("R8 mode", 32'(wire3_o), 32'd1);

    // R7: partial exec command aborted, then clocks while deselected
    sel;
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    desel;
    for (int i = 0; i < 8; i++) send_bit(i == 3);
    sclk_i = 1'b0; wait_clk(10);
    chk("R7 no strobe", 32'(seen), 32'd2);
    sel;
    send_cmd(4'd3, 4'h1); send_cmd(4'd4, 4'hE); send_cmd(4'd8, 4'h0);
    desel;
    chk("R7 clean restart", 32'(seen), 32'd3);
    chk("R7 data", 32'(last_data), 32'h15C3);
    chk("R1 index", 32'(last_idx), 32'hE);

    // R5: mode register
    sel; send_cmd(4'd15, 4'h0); desel;
    chk("R5 four-wire", 32'(wire3_o), 32'd0);
    sel; send_cmd(4'd15, 4'h7); desel;
    chk("R5 ignored value", 32'(wire3_o), 32'd0);
    sel; send_cmd(4'd15, 4'h1); desel;
    chk("R5 three-wire", 32'(wire3_o), 32'd1);
    sel; send_cmd(4'd15, 4'h0); send_cmd(4'd15, 4'h2); desel;
    chk("R5 stays four-wire", 32'(wire3_o), 32'd0);
    chk("R9 driver off end", 32'(do_oe_o), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule